// File: doc/BRIEF.md
# Source-Synchronous Bus Address Receiver

This block is the receiving end of the address phase on a shared multi-agent processor bus. The bus lines are active-low. Two strobe lanes clock groups of address, request and parity lines. The rising strobe edge captures the first half of the phase, which is the physical address of bits 37 down to 3. The falling edge captures the second half, where the same lines carry transaction-type information. Each lane keeps its own capture registers. The core clock domain learns that a lane has finished through a toggle that passes through a synchronizer.

A falling address-strobe input, sampled on the core clock, opens a transaction. Once both lanes have finished a capture, the block checks the two address parity bits and puts the request into a two-entry buffer, which hands it to the core through a valid/ready pair. A request that meets a full buffer is dropped and sets a sticky overflow flag. On the first core clock after reset is released, a small field of the address lines is latched as a power-on configuration word.

Top module: `ssync_addr_rx`

## Requirements
- R1: While reset is asserted and right after its release, `rq_valid`, `par_err` and `ovf` are all 0.
- R2: `rq_addr` is the active-high value of the address lines at the rising strobe edge. `rq_kind` and `rq_reqb` are the active-high values at the falling edge. `rq_reqa` is the request lines at the rising edge.
- R3: Strobe lane 0 captures the request lines, the parity lines, address bits 16:3 and address bits 37:36. Strobe lane 1 captures address bits 35:17. Each lane holds what was on its own lines at its own edge, so lines that change between the two lanes' edges end up merged by group.
- R4: Parity bit 0 makes address bits 23:3 plus itself even, and parity bit 1 does the same for bits 37:24. All are active-high values of the first-half capture. A mismatch raises `par_err` for exactly one core cycle, and the request is still delivered.
- R5: A request is formed only after `ads_n` goes from 1 to 0 on the core clock and both lanes have completed a falling edge. Strobes without that transition deliver nothing.
- R6: The buffer holds two requests. A request formed while it is full is dropped and sets `ovf`, which stays 1 until reset.
- R7: `cfg` equals the active-high address bits 31:27, with bit 27 in `cfg[0]`, sampled on the first core clock after `rst_n` rises. It keeps that value until the next reset.
- R8: While `rq_valid` is 1 and `rq_ready` is 0, the head request and `rq_valid` hold. Requests leave in the order they were formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Reset, active-low, asynchronous assert |
| addr_n | input | 35 | Address lines, bits 37:3, active-low |
| req_n | input | 5 | Request lines, active-low |
| apar_n | input | 2 | Address parity lines, active-low |
| astb_n | input | 2 | Strobe lanes 1 and 0 (rise = first half, fall = second half) |
| ads_n | input | 1 | Address-valid strobe, active-low, core clock |
| rq_ready | input | 1 | Core accepts the head request |
| rq_valid | output | 1 | A request is waiting |
| rq_addr | output | 35 | Physical address bits 37:3 |
| rq_kind | output | 35 | Transaction-type information from the second half |
| rq_reqa | output | 5 | Request lines, first half |
| rq_reqb | output | 5 | Request lines, second half |
| par_err | output | 1 | One-cycle parity mismatch pulse |
| ovf | output | 1 | Sticky dropped-request flag |
| cfg | output | 5 | Power-on configuration word |

## Verification
A parity mismatch and an overflow drop can come from the same request formation. In that case the error pulse and the overflow flag rise on the same core edge. The bench provokes this by filling the two-entry buffer with `rq_ready` held low and then sending a third transaction with a deliberately wrong parity bit. The case passes when `ovf` becomes 1, the parity pulse count goes up by exactly one, and after the two stored requests drain, no third request appears.

// File: rtl/ssync_rx_pkg.sv
package ssync_rx_pkg;
   localparam int unsigned ADDR_LO_D     = 3;
   localparam int unsigned ADDR_HI_D     = 37;
   localparam int unsigned REQ_W_D       = 5;
   localparam int unsigned LANE0_TOP_D   = 16;
   localparam int unsigned LANE1_TOP_D   = 35;
   localparam int unsigned PAR_SPLIT_D   = 23;
   localparam int unsigned CFG_LSB_D     = 27;
   localparam int unsigned CFG_W_D       = 5;
   localparam int unsigned FIFO_DEPTH_D  = 2;
   localparam int unsigned SYNC_STAGES_D = 2;
   localparam int unsigned NUM_LANES     = 2;

   typedef logic [1:0] par_pair_t;
endpackage

// File: rtl/ssync_lane_cap.sv
module ssync_lane_cap #(
   parameter int unsigned W  = 8,
   parameter int unsigned W2 = 8
) (
   input  logic          stb,
   input  logic          rst_n,
   input  logic [W-1:0]  d_n,
   output logic [W-1:0]  ph1_q,
   output logic [W2-1:0] ph2_q,
   output logic          done_tog
);
   if (W2 > W || W2 == 0) begin : g_bad_w
      $error("ssync_lane_cap: W2 must be in 1..W");
   end

   // First half of the phase: rising strobe edge
   always_ff @(posedge stb or negedge rst_n) begin
      if (!rst_n) ph1_q <= '1;
      else        ph1_q <= d_n;
   end

   // Second half: falling edge, lane completion toggles
   always_ff @(negedge stb or negedge rst_n) begin
      if (!rst_n) begin
         ph2_q    <= '1;
         done_tog <= 1'b0;
      end else begin
         ph2_q    <= d_n[W2-1:0];
         done_tog <= ~done_tog;
      end
   end
endmodule

// File: rtl/ssync_bit_sync.sv
module ssync_bit_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ssync_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/ssync_req_fifo.sv
module ssync_req_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid
);
   localparam int unsigned PW = $clog2(DEPTH);
   localparam int unsigned CW = PW + 1;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("ssync_req_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign full  = (cnt == CW'(DEPTH));
   assign valid = (cnt != '0);
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // R6: occupancy never passes the depth
   p_cnt_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R8: head entry held while not popped
   p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop) |=> (valid && $stable(dout)));
endmodule

// File: rtl/ssync_addr_rx.sv
module ssync_addr_rx
   import ssync_rx_pkg::*;
#(
   parameter int unsigned ADDR_LO     = ADDR_LO_D,
   parameter int unsigned ADDR_HI     = ADDR_HI_D,
   parameter int unsigned REQ_W       = REQ_W_D,
   parameter int unsigned LANE0_TOP   = LANE0_TOP_D,
   parameter int unsigned LANE1_TOP   = LANE1_TOP_D,
   parameter int unsigned PAR_SPLIT   = PAR_SPLIT_D,
   parameter int unsigned CFG_LSB     = CFG_LSB_D,
   parameter int unsigned CFG_W       = CFG_W_D,
   parameter int unsigned FIFO_DEPTH  = FIFO_DEPTH_D,
   parameter int unsigned SYNC_STAGES = SYNC_STAGES_D,
   localparam int unsigned AW = ADDR_HI - ADDR_LO + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_n,
   input  logic [REQ_W-1:0] req_n,
   input  logic [1:0]       apar_n,
   input  logic [1:0]       astb_n,
   input  logic             ads_n,
   input  logic             rq_ready,
   output logic             rq_valid,
   output logic [AW-1:0]    rq_addr,
   output logic [AW-1:0]    rq_kind,
   output logic [REQ_W-1:0] rq_reqa,
   output logic [REQ_W-1:0] rq_reqb,
   output logic             par_err,
   output logic             ovf,
   output logic [CFG_W-1:0] cfg
);
   localparam int unsigned LW  = LANE0_TOP - ADDR_LO + 1;
   localparam int unsigned MW  = LANE1_TOP - LANE0_TOP;
   localparam int unsigned HW  = ADDR_HI - LANE1_TOP;
   localparam int unsigned L0W = REQ_W + LW + HW + 2;
   localparam int unsigned L0P = REQ_W + LW + HW;
   localparam int unsigned PSI = PAR_SPLIT - ADDR_LO;
   localparam int unsigned CFI = CFG_LSB - ADDR_LO;
   localparam int unsigned PLW = 2 * AW + 2 * REQ_W;

   if (!(ADDR_LO <= LANE0_TOP && LANE0_TOP < LANE1_TOP && LANE1_TOP < ADDR_HI)) begin : g_bad_lanes
      $error("ssync_addr_rx: lane boundaries out of order");
   end
   if (!(PAR_SPLIT >= ADDR_LO && PAR_SPLIT < ADDR_HI)) begin : g_bad_par
      $error("ssync_addr_rx: parity split outside address range");
   end
   if (CFG_LSB < ADDR_LO || CFG_LSB + CFG_W - 1 > ADDR_HI) begin : g_bad_cfg
      $error("ssync_addr_rx: configuration field outside address range");
   end

   // ---------------- strobe lanes ----------------
   logic [L0W-1:0]   l0_ph1_n;
   logic [L0P-1:0]   l0_ph2_n;
   logic [MW-1:0]    l1_ph1_n, l1_ph2_n;
   logic [NUM_LANES-1:0] tog_raw, tog_s;

   ssync_lane_cap #(.W(L0W), .W2(L0P)) u_lane0 (
      .stb      (astb_n[0]),
      .rst_n    (rst_n),
      .d_n      ({apar_n, addr_n[AW-1:AW-HW], addr_n[LW-1:0], req_n}),
      .ph1_q    (l0_ph1_n),
      .ph2_q    (l0_ph2_n),
      .done_tog (tog_raw[0])
   );

   ssync_lane_cap #(.W(MW), .W2(MW)) u_lane1 (
      .stb      (astb_n[1]),
      .rst_n    (rst_n),
      .d_n      (addr_n[LW+MW-1:LW]),
      .ph1_q    (l1_ph1_n),
      .ph2_q    (l1_ph2_n),
      .done_tog (tog_raw[1])
   );

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_sync
      ssync_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (tog_raw[k]),
         .q     (tog_s[k])
      );
   end

   // ---------------- reassembly (active-high) ----------------
   logic [L0W-1:0]   l0a;
   logic [L0P-1:0]   l0b;
   logic [AW-1:0]    a1, a2;
   logic [REQ_W-1:0] ra, rb;
   par_pair_t        par_rx, par_calc;
   logic             par_bad;

   assign l0a = ~l0_ph1_n;
   assign l0b = ~l0_ph2_n;
   assign a1  = {l0a[L0P-1:REQ_W+LW], ~l1_ph1_n, l0a[REQ_W+LW-1:REQ_W]};
   assign a2  = {l0b[L0P-1:REQ_W+LW], ~l1_ph2_n, l0b[REQ_W+LW-1:REQ_W]};
   assign ra  = l0a[REQ_W-1:0];
   assign rb  = l0b[REQ_W-1:0];
   assign par_rx      = l0a[L0W-1:L0P];
   assign par_calc[0] = ^a1[PSI:0];
   assign par_calc[1] = ^a1[AW-1:PSI+1];
   assign par_bad     = (par_rx != par_calc);

   // ---------------- core-side qualification ----------------
   logic                 ads_prev_n, ads_fall, pend;
   logic [NUM_LANES-1:0] tog_d, fresh;
   logic                 form, full, push, pop;

   assign ads_fall = ads_prev_n & ~ads_n;
   assign form     = pend & (&fresh);
   assign push     = form & ~full;
   assign pop      = rq_valid & rq_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ads_prev_n <= 1'b1;
         pend       <= 1'b0;
         tog_d      <= '0;
         fresh      <= '0;
         par_err    <= 1'b0;
         ovf        <= 1'b0;
      end else begin
         ads_prev_n <= ads_n;
         pend       <= ads_fall | (pend & ~form);
         tog_d      <= tog_s;
         fresh      <= (fresh & {NUM_LANES{~form}}) | (tog_s ^ tog_d);
         par_err    <= form & par_bad;
         ovf        <= ovf | (form & full);
      end
   end

   // ---------------- handoff buffer ----------------
   logic [PLW-1:0] pl_in, pl_out;
   assign pl_in = {a1, a2, ra, rb};

   ssync_req_fifo #(.W(PLW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (pl_in),
      .full  (full),
      .pop   (pop),
      .dout  (pl_out),
      .valid (rq_valid)
   );

   assign {rq_addr, rq_kind, rq_reqa, rq_reqb} = pl_out;

   // ---------------- power-on configuration ----------------
   logic rel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= 1'b0;
         cfg   <= '0;
      end else begin
         rel_q <= 1'b1;
         if (!rel_q) cfg <= ~addr_n[CFI+CFG_W-1:CFI];
      end
   end

   // ---------------- assertions ----------------
   // R4: error pulse lasts one cycle
   p_par_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> !par_err);
   // R6: overflow flag is sticky
   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R7: configuration constant once captured
   p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rel_q |=> $stable(cfg));
   // R8: valid holds while the core stalls
   p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && !rq_ready) |=> rq_valid);
   // R5: no buffer entry without a pending address strobe
   p_push_needs_ads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> pend);
endmodule

// File: tb/ssync_addr_rx_tb_top.sv
module ssync_addr_rx_tb_top;
   localparam int AW = 35;
   localparam int RW = 5;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr_n;
   logic [RW-1:0] req_n;
   logic [1:0]    apar_n, astb_n;
   logic          ads_n, rq_ready;
   logic          rq_valid, par_err, ovf;
   logic [AW-1:0] rq_addr, rq_kind;
   logic [RW-1:0] rq_reqa, rq_reqb;
   logic [CW-1:0] cfg;

   always #4 clk = ~clk;

   ssync_addr_rx dut_i (
      .clk(clk), .rst_n(rst_n), .addr_n(addr_n), .req_n(req_n), .apar_n(apar_n),
      .astb_n(astb_n), .ads_n(ads_n), .rq_ready(rq_ready), .rq_valid(rq_valid),
      .rq_addr(rq_addr), .rq_kind(rq_kind), .rq_reqa(rq_reqa), .rq_reqb(rq_reqb),
      .par_err(par_err), .ovf(ovf), .cfg(cfg)
   );

   int total = 0;
   int bad   = 0;
   int par_seen = 0;
   int par_exp  = 0;
   bit ovf_exp  = 0;
   bit done     = 0;
   logic [79:0] expq [$];

   always @(negedge clk) if (par_err) par_seen++;

   task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] merge(logic [AW-1:0] x, logic [AW-1:0] y);
      logic [AW-1:0] m = x;
      m[32:14] = y[32:14];   // lane 1 owns bits 35:17
      return m;
   endfunction

   function automatic logic [1:0] par_of(logic [AW-1:0] a);
      return {^a[34:21], ^a[20:0]};
   endfunction

   function automatic logic [AW-1:0] rnd_addr();
      logic [63:0] r = {$urandom, $urandom};
      return r[AW-1:0];
   endfunction

   task automatic xfer(logic [AW-1:0] ax, logic [AW-1:0] ay, logic [AW-1:0] t2,
                       logic [RW-1:0] ra, logic [RW-1:0] rb, bit badp, bit do_ads);
      logic [AW-1:0] m = merge(ax, ay);
      logic [1:0]    p = par_of(m) ^ {1'b0, badp};
      addr_n = ~ax; req_n = ~ra; apar_n = ~p;
      #1 astb_n[0] = 1'b1;
      #1 addr_n = ~ay;
      #1 astb_n[1] = 1'b1;
      #1 addr_n = ~t2; req_n = ~rb;
      #1 astb_n = 2'b00;
      repeat (4) @(negedge clk);
      if (do_ads) begin
         ads_n = 1'b0;
         @(negedge clk);
         ads_n = 1'b1;
         if (badp) par_exp++;
         if (expq.size() == 2) ovf_exp = 1'b1;
         else expq.push_back({m, t2, ra, rb});
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic pop_chk(string rq);
      chk({rq, " valid"}, 128'(rq_valid), 128'(expq.size() != 0));
      if (expq.size() != 0) begin
         chk({rq, " payload"}, 128'({rq_addr, rq_kind, rq_reqa, rq_reqb}), 128'(expq[0]));
         rq_ready = 1'b1;
         @(negedge clk);
         rq_ready = 1'b0;
         void'(expq.pop_front());
      end
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] x, y;
      void'($urandom(32'd2718));
      rst_n = 1'b0; astb_n = 2'b00; ads_n = 1'b1; rq_ready = 1'b0;
      req_n = '1; apar_n = '1;
      addr_n = ~(AW'(5'b10110) << 24);     // address bits 31:27 = 10110
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 128'(rq_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 valid", 128'(rq_valid), 0);
      chk("R1 ovf", 128'(ovf), 0);
      chk("R1 par_err", 128'(par_err), 0);
      chk("R7 cfg capture", 128'(cfg), 128'(5'b10110));

      // R2 basic split of halves
      xfer(35'h5_1234_5678, 35'h5_1234_5678, 35'h2_ABCD_0F0F, 5'h13, 5'h0C, 0, 1);
      pop_chk("R2 basic");

      // R4 bad parity, still delivered
      xfer(35'h0_00FF_0001, 35'h0_00FF_0001, 35'h1, 5'h1, 5'h2, 1, 1);
      pop_chk("R4 bad parity delivered");
      chk("R4 parity pulses", 128'(par_seen), 128'(par_exp));

      // R5 strobes without address strobe
      xfer(35'h7_0000_0001, 35'h7_0000_0001, 35'h3, 5'h4, 5'h5, 0, 0);
      chk("R5 no request without ads", 128'(rq_valid), 0);

      // R3 lane grouping with lines changing between lane edges
      x = 35'h7_FFFF_FFFF; y = 35'h0;
      xfer(x, y, 35'h4_4444_4444, 5'h1F, 5'h00, 0, 1);
      chk("R3 merged address", 128'(rq_addr), 128'(35'h6_0000_3FFF));
      pop_chk("R3 merged");

      // R8 order and hold under stall
      xfer(35'h1_1111_1111, 35'h1_1111_1111, 35'h2, 5'h3, 5'h4, 0, 1);
      xfer(35'h2_2222_2222, 35'h2_2222_2222, 35'h5, 5'h6, 5'h7, 0, 1);
      repeat (5) @(negedge clk);
      chk("R8 held valid", 128'(rq_valid), 1);
      pop_chk("R8 first");
      pop_chk("R8 second");
      chk("R8 drained", 128'(rq_valid), 0);

      // R6 overflow together with parity error (same formation)
      xfer(35'h3_0000_0003, 35'h3_0000_0003, 35'h8, 5'h8, 5'h9, 0, 1);
      xfer(35'h3_0000_0004, 35'h3_0000_0004, 35'h9, 5'hA, 5'hB, 0, 1);
      chk("R6 ovf before full drop", 128'(ovf), 0);
      xfer(35'h3_0000_0005, 35'h3_0000_0005, 35'hA, 5'hC, 5'hD, 1, 1);
      chk("R6 ovf set", 128'(ovf), 128'(ovf_exp));
      chk("R4 parity pulse on dropped request", 128'(par_seen), 128'(par_exp));
      pop_chk("R6 keep first");
      pop_chk("R6 keep second");
      chk("R6 dropped not delivered", 128'(rq_valid), 0);
      chk("R6 ovf sticky", 128'(ovf), 1);

      // random mix
      for (int i = 0; i < 16; i++) begin
         logic [AW-1:0] a = rnd_addr();
         logic [AW-1:0] t = rnd_addr();
         logic [7:0] r = 8'($urandom);
         bit bp = ($urandom % 4) == 0;
         xfer(a, a, t, r[4:0], RW'(r[7:3]), bp, 1);
         pop_chk("R2 random");
      end
      chk("R4 random parity pulses", 128'(par_seen), 128'(par_exp));
      chk("R7 cfg constant", 128'(cfg), 128'(5'b10110));

      // second reset, new configuration
      rst_n = 1'b0;
      addr_n = ~(AW'(5'b01001) << 24);
      expq.delete(); ovf_exp = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 ovf cleared", 128'(ovf), 0);
      chk("R1 valid after reset", 128'(rq_valid), 0);
      chk("R7 cfg recapture", 128'(cfg), 128'(5'b01001));

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule